// File: doc/BRIEF.md
# Low-Power DDR SDRAM Power-Up Sequencer

This block is the start-up engine of a memory controller for a low-power DDR SDRAM. From reset it holds clock-enable high and keeps the command bus idle for a programmable number of clock cycles. That count is set from the clock frequency so that it covers at least 200 us. It then plays out the fixed bring-up program: one precharge of all banks, two auto-refreshes, and one load each of the base and the extended mode register. Every command is followed by its own run of idle cycles.

Two parameters change the order of the program. One places the two refreshes either straight after the precharge gap or after both register loads. The other decides which mode register is loaded first. The register values and every wait length are parameters. A sticky done flag tells the rest of the controller that normal traffic may begin.

All waits come from a single down-counter. The counter is reloaded with the gap length each time a command goes out, and the next command follows in the cycle after it reaches zero.

Top module: `lpddr_powerup_seq`

## Requirements
- R1: `cke_o` is 1 in every cycle, during reset and after it.
- R2: Cycle 0 is the cycle that follows the last rising edge at which `rst_n` is sampled low. Cycles 0 to STARTUP_CYC-1 carry only idle commands, and the precharge-all command appears in cycle STARTUP_CYC.
- R3: Precharge-all drives {cs_n,ras_n,cas_n,we_n} = 0010 with address bit 10 = 1, all other address bits 0 and bank address 0. The next command comes exactly T_RP+1 cycles later.
- R4: Exactly two auto-refresh commands are issued per sequence, each as 0001 with address and bank address 0. Each is followed by exactly T_RFC idle cycles before the next command or done.
- R5: The base mode load drives 0000 with bank address 00 and BASE_MODE zero-extended on the address bus. The extended load drives 0000 with bank address 10 and EXT_MODE on the address bus. Each load is followed by exactly T_MRD idle cycles before the next command or done.
- R6: With EXT_FIRST = 0 the base load precedes the extended load; with EXT_FIRST = 1 the extended load comes first.
- R7: With REF_LATE = 0 the order is precharge, refresh, refresh, load, load. With REF_LATE = 1 it is precharge, load, load, refresh, refresh.
- R8: `done_o` rises in the cycle right after the idle gap of the fifth command. It then stays 1 with an idle bus until reset.
- R9: A synchronous active-low reset, applied at any point in the sequence or after done, forces an idle bus and `done_o` = 0 in the cycle after the edge that samples it. After release the sequence restarts from the start-up wait.
- R10: The idle command is 0111 with address and bank address driven 0. Every command occupies one cycle and is followed by at least one idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cke_o | output | 1 | Clock enable to the memory |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Address bus |
| done_o | output | 1 | Sequence complete, sticky until reset |

## Verification
The bench builds four copies of the block side by side, one for each setting of REF_LATE and EXT_FIRST. It shortens the start-up wait to 20 cycles and sets T_RP = 3, T_RFC = 5 and T_MRD = 2. These values make every gap distinct, so a command that takes the wrong wait lands in a wrong cycle. Because all four orderings run under the same stimulus, each command slot is checked for every position a refresh or a register load can take. The short wait also allows three runs per copy: a full sequence, a reset after done, and a reset in the middle of the program.

// File: rtl/lpddr_init_pkg.sv
package lpddr_init_pkg;

   typedef enum logic [3:0] {
      PIN_NOP = 4'b0111,
      PIN_PRE = 4'b0010,
      PIN_REF = 4'b0001,
      PIN_LMR = 4'b0000
   } pin_cmd_e;

   typedef enum logic [1:0] {
      K_PRE,
      K_REF,
      K_MRB,
      K_MRE
   } slot_kind_e;

   localparam int NUM_SLOTS = 5;
   localparam int STEP_W    = $clog2(NUM_SLOTS + 2);
   localparam int STEP_DONE = NUM_SLOTS + 1;
   localparam int A10_POS   = 10;

endpackage

// File: rtl/lpddr_init_plan.sv
module lpddr_init_plan
   import lpddr_init_pkg::*;
#(
   parameter bit REF_LATE  = 1'b0,
   parameter bit EXT_FIRST = 1'b0
) (
   input  logic [STEP_W-1:0] step_i,
   output slot_kind_e        kind_o
);

   localparam slot_kind_e MR_A = EXT_FIRST ? K_MRE : K_MRB;
   localparam slot_kind_e MR_B = EXT_FIRST ? K_MRB : K_MRE;

   generate
      if (REF_LATE) begin : g_ref_late
         always_comb begin
            case (step_i)
               STEP_W'(2): kind_o = MR_A;
               STEP_W'(3): kind_o = MR_B;
               STEP_W'(4): kind_o = K_REF;
               STEP_W'(5): kind_o = K_REF;
               default:    kind_o = K_PRE;
            endcase
         end
      end else begin : g_ref_early
         always_comb begin
            case (step_i)
               STEP_W'(2): kind_o = K_REF;
               STEP_W'(3): kind_o = K_REF;
               STEP_W'(4): kind_o = MR_A;
               STEP_W'(5): kind_o = MR_B;
               default:    kind_o = K_PRE;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/lpddr_init_timer.sv
module lpddr_init_timer #(
   parameter int               CNT_W   = 8,
   parameter logic [CNT_W-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             zero_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= RST_VAL;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/lpddr_init_cmdgen.sv
module lpddr_init_cmdgen
   import lpddr_init_pkg::*;
#(
   parameter int                ADDR_W    = 13,
   parameter int                BA_W      = 2,
   parameter int                MODE_W    = 12,
   parameter logic [MODE_W-1:0] BASE_MODE = '0,
   parameter logic [MODE_W-1:0] EXT_MODE  = '0
) (
   input  logic              issue_i,
   input  slot_kind_e        kind_i,
   output logic [3:0]        cmd_o,
   output logic [BA_W-1:0]   ba_o,
   output logic [ADDR_W-1:0] addr_o
);

   localparam logic [ADDR_W-1:0] PRE_ADDR  = ADDR_W'(1) << A10_POS;
   localparam logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'(BASE_MODE);
   localparam logic [ADDR_W-1:0] EXT_ADDR  = ADDR_W'(EXT_MODE);
   localparam logic [BA_W-1:0]   BA_BASE   = '0;
   localparam logic [BA_W-1:0]   BA_EXT    = BA_W'(2);

   always_comb begin
      cmd_o  = PIN_NOP;
      ba_o   = '0;
      addr_o = '0;
      if (issue_i) begin
         case (kind_i)
            K_PRE: begin
               cmd_o  = PIN_PRE;
               addr_o = PRE_ADDR;
            end
            K_REF: cmd_o = PIN_REF;
            K_MRB: begin
               cmd_o  = PIN_LMR;
               ba_o   = BA_BASE;
               addr_o = BASE_ADDR;
            end
            default: begin
               cmd_o  = PIN_LMR;
               ba_o   = BA_EXT;
               addr_o = EXT_ADDR;
            end
         endcase
      end
   end

endmodule

// File: rtl/lpddr_powerup_seq.sv
module lpddr_powerup_seq
   import lpddr_init_pkg::*;
#(
   parameter int                ADDR_W      = 13,
   parameter int                BA_W        = 2,
   parameter int                MODE_W      = 12,
   parameter int                STARTUP_CYC = 40000,
   parameter int                T_RP        = 4,
   parameter int                T_RFC       = 16,
   parameter int                T_MRD       = 2,
   parameter logic [MODE_W-1:0] BASE_MODE   = 12'h032,
   parameter logic [MODE_W-1:0] EXT_MODE    = 12'h000,
   parameter bit                REF_LATE    = 1'b0,
   parameter bit                EXT_FIRST   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              cke_o,
   output logic              cs_n_o,
   output logic              ras_n_o,
   output logic              cas_n_o,
   output logic              we_n_o,
   output logic [BA_W-1:0]   ba_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              done_o
);

   localparam int MAX_GAP  = (T_RP > T_RFC) ? ((T_RP > T_MRD) ? T_RP : T_MRD)
                                            : ((T_RFC > T_MRD) ? T_RFC : T_MRD);
   localparam int MAX_WAIT = (STARTUP_CYC > MAX_GAP) ? STARTUP_CYC : MAX_GAP;
   localparam int CNT_W    = $clog2(MAX_WAIT + 1);

   generate
      if (STARTUP_CYC < 2) begin : g_bad_startup
         $error("STARTUP_CYC must be at least 2");
      end
      if (T_RP < 1 || T_RFC < 1 || T_MRD < 1) begin : g_bad_gap
         $error("every command gap must be at least one cycle");
      end
      if (ADDR_W <= A10_POS || ADDR_W < MODE_W) begin : g_bad_addr
         $error("address bus too narrow for bit 10 or the mode value");
      end
      if (BA_W < 2) begin : g_bad_ba
         $error("bank address needs at least two bits");
      end
   endgenerate

   logic [STEP_W-1:0] step_q;
   logic              issue_q;
   logic              zero;
   slot_kind_e        kind;
   logic [CNT_W-1:0]  gap_m1;
   logic [3:0]        cmd;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         step_q  <= '0;
         issue_q <= 1'b0;
      end else if (issue_q) begin
         issue_q <= 1'b0;
      end else if (step_q != STEP_W'(STEP_DONE) && zero) begin
         if (step_q == STEP_W'(NUM_SLOTS)) begin
            step_q <= STEP_W'(STEP_DONE);
         end else begin
            step_q  <= step_q + STEP_W'(1);
            issue_q <= 1'b1;
         end
      end
   end

   lpddr_init_plan #(
      .REF_LATE  (REF_LATE),
      .EXT_FIRST (EXT_FIRST)
   ) u_plan (
      .step_i (step_q),
      .kind_o (kind)
   );

   always_comb begin
      case (kind)
         K_PRE:   gap_m1 = CNT_W'(T_RP - 1);
         K_REF:   gap_m1 = CNT_W'(T_RFC - 1);
         default: gap_m1 = CNT_W'(T_MRD - 1);
      endcase
   end

   lpddr_init_timer #(
      .CNT_W   (CNT_W),
      .RST_VAL (CNT_W'(STARTUP_CYC - 1))
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (issue_q),
      .load_val_i (gap_m1),
      .zero_o     (zero)
   );

   lpddr_init_cmdgen #(
      .ADDR_W    (ADDR_W),
      .BA_W      (BA_W),
      .MODE_W    (MODE_W),
      .BASE_MODE (BASE_MODE),
      .EXT_MODE  (EXT_MODE)
   ) u_cmdgen (
      .issue_i (issue_q),
      .kind_i  (kind),
      .cmd_o   (cmd),
      .ba_o    (ba_o),
      .addr_o  (addr_o)
   );

   assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd;
   assign cke_o  = 1'b1;
   assign done_o = (step_q == STEP_W'(STEP_DONE));

endmodule

// File: rtl/lpddr_powerup_seq_chk.sv
module lpddr_powerup_seq_chk #(
   parameter int ADDR_W      = 13,
   parameter int BA_W        = 2,
   parameter int STARTUP_CYC = 40000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n_o,
   input logic              ras_n_o,
   input logic              cas_n_o,
   input logic              we_n_o,
   input logic [BA_W-1:0]   ba_o,
   input logic [ADDR_W-1:0] addr_o,
   input logic              done_o
);

   localparam int QW = $clog2(STARTUP_CYC + 1);

   logic [3:0]    pins;
   logic          is_nop;
   logic [QW-1:0] quiet_q;
   logic [1:0]    refs_q;

   assign pins   = {cs_n_o, ras_n_o, cas_n_o, we_n_o};
   assign is_nop = (pins == 4'b0111);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         quiet_q <= '0;
         refs_q  <= '0;
      end else begin
         if (quiet_q != QW'(STARTUP_CYC)) quiet_q <= quiet_q + QW'(1);
         if (pins == 4'b0001 && refs_q != 2'd3) refs_q <= refs_q + 2'd1;
      end
   end

   p_startup_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet_q < QW'(STARTUP_CYC)) |-> is_nop);

   p_pre_a10_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pins == 4'b0010) |-> addr_o[10]);

   p_ref_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      refs_q <= 2'd2);

   p_lmr_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pins == 4'b0000) |-> (ba_o == BA_W'(0) || ba_o == BA_W'(2)));

   p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> done_o);

   p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (is_nop && refs_q == 2'd2));

   p_reset_clears_r9: assert property (@(posedge clk)
      !rst_n |=> (!done_o && is_nop));

   p_single_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !is_nop |=> is_nop);

endmodule

bind lpddr_powerup_seq lpddr_powerup_seq_chk #(
   .ADDR_W      (ADDR_W),
   .BA_W        (BA_W),
   .STARTUP_CYC (STARTUP_CYC)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cs_n_o  (cs_n_o),
   .ras_n_o (ras_n_o),
   .cas_n_o (cas_n_o),
   .we_n_o  (we_n_o),
   .ba_o    (ba_o),
   .addr_o  (addr_o),
   .done_o  (done_o)
);

// File: tb/lpddr_powerup_seq_bench.sv
`timescale 1ns/1ps
module lpddr_powerup_seq_bench;

   localparam int S      = 20;
   localparam int TRP    = 3;
   localparam int TRFC   = 5;
   localparam int TMRD   = 2;
   localparam int AW     = 13;
   localparam logic [11:0] BASEV = 12'h033;
   localparam logic [11:0] EXTV  = 12'h420;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rst_seen = 1'b0;
   logic finished = 1'b0;

   always #2.5 clk = ~clk;
   always @(posedge clk) rst_seen <= rst_n;

   function automatic int exp_kind(int late, int extf, int n);
      int mra = extf ? 3 : 2;
      int mrb = extf ? 2 : 3;
      if (n == 1) return 0;
      if (late == 0) return (n <= 3) ? 1 : ((n == 4) ? mra : mrb);
      return (n == 2) ? mra : ((n == 3) ? mrb : 1);
   endfunction

   function automatic int gap_of(int k);
      return (k == 0) ? TRP : ((k == 1) ? TRFC : TMRD);
   endfunction

   function automatic logic [18:0] pins_of(int k);
      case (k)
         0:       return {4'b0010, 2'b00, AW'(1) << 10};
         1:       return {4'b0001, 2'b00, AW'(0)};
         2:       return {4'b0000, 2'b00, AW'(BASEV)};
         default: return {4'b0000, 2'b10, AW'(EXTV)};
      endcase
   endfunction

   for (genvar gi = 0; gi < 4; gi++) begin : g_cfg
      localparam int LATE = gi / 2;
      localparam int EXTF = gi % 2;

      logic cke, cs_n, ras_n, cas_n, we_n, done;
      logic [1:0]    ba;
      logic [AW-1:0] addr;
      int n_chk = 0;
      int n_err = 0;
      int cyc, ncmd, exp_next, exp_done;

      lpddr_powerup_seq #(
         .ADDR_W (AW), .BA_W (2), .MODE_W (12), .STARTUP_CYC (S),
         .T_RP (TRP), .T_RFC (TRFC), .T_MRD (TMRD),
         .BASE_MODE (BASEV), .EXT_MODE (EXTV),
         .REF_LATE (LATE[0]), .EXT_FIRST (EXTF[0])
      ) u_lpddr_powerup_seq (
         .clk (clk), .rst_n (rst_n), .cke_o (cke),
         .cs_n_o (cs_n), .ras_n_o (ras_n), .cas_n_o (cas_n), .we_n_o (we_n),
         .ba_o (ba), .addr_o (addr), .done_o (done)
      );

      task automatic check(input bit ok, input string tag, input logic [31:0] act,
                           input logic [31:0] expv);
         n_chk++;
         if (!ok) begin
            n_err++;
            $display("FAIL %s cfg%0d cyc %0d: actual %0h expected %0h", tag, gi, cyc, act, expv);
         end
      endtask

      always @(negedge clk) begin
         logic [18:0] bus;
         bus = {cs_n, ras_n, cas_n, we_n, ba, addr};
         check(cke === 1'b1, "R1 cke", 32'(cke), 32'd1);
         if (!rst_seen) begin
            check(bus === {4'b0111, 2'b00, AW'(0)}, "R9 idle in reset", 32'(bus), 32'h38000);
            check(done === 1'b0, "R9 done low in reset", 32'(done), 32'd0);
            cyc = 1; ncmd = 0; exp_next = S; exp_done = -1;
         end else begin
            if (bus[18:15] !== 4'b0111) begin
               int k;
               ncmd++;
               k = exp_kind(LATE, EXTF, ncmd);
               check(ncmd <= 5, "R4 command count", 32'(ncmd), 32'd5);
               check(cyc == exp_next, (ncmd == 1) ? "R2 startup wait" : "R3 R4 R5 gap",
                     32'(cyc), 32'(exp_next));
               check(bus === pins_of(k), (LATE != 0) ? "R7 R6 order late" : "R7 R6 order early",
                     32'(bus), 32'(pins_of(k)));
               exp_next = cyc + gap_of(k) + 1;
               if (ncmd == 5) exp_done = exp_next;
            end else begin
               check(bus === {4'b0111, 2'b00, AW'(0)}, "R10 idle", 32'(bus), 32'h38000);
            end
            check(done === (exp_done >= 0 && cyc >= exp_done), "R8 done",
                  32'(done), 32'(exp_done >= 0 && cyc >= exp_done));
            cyc++;
         end
      end
   end

   task automatic report(input bit timeout);
      int tc, te;
      tc = g_cfg[0].n_chk + g_cfg[1].n_chk + g_cfg[2].n_chk + g_cfg[3].n_chk;
      te = g_cfg[0].n_err + g_cfg[1].n_err + g_cfg[2].n_err + g_cfg[3].n_err;
      if (timeout) begin
         tc++; te++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("End of test - %0d assertions evaluated, %0d failures", tc, te);
      $finish;
   endtask

   initial begin
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;                 // run 1: full sequence, done sticky (R8)
      repeat (80) @(posedge clk);
      #1 rst_n = 1'b0;                 // R9: reset after done
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
      repeat (28) @(posedge clk);      // mid-sequence
      #1 rst_n = 1'b0;                 // R9: reset mid sequence
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
      repeat (80) @(posedge clk);
      @(negedge clk);
      finished = 1'b1;
      report(1'b0);
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) report(1'b1);
   end

endmodule